// File: doc/BRIEF.md
# Binary-Weighted Spread-Pulse Modulator

This block drives a single-bit digital-to-analog output whose mean level follows an N-bit input code. A free-running N-bit counter defines a conversion period of 2^N clocks. Code bit k does not add to one long pulse. Instead it contributes a pulse of 2^k clocks, placed in the first stretch of the period during which counter bit k is high. The pulses of all set code bits are merged by OR into one line.

The on-time is therefore split into binary-weighted pieces laid out from the narrowest, near the start of the period, to the widest, at its end. The duty cycle stays code/2^N, but the switching edges are spread over the whole period. An external low-pass filter recovers the mean level.

The code is sampled only at the period boundary, so the code applied to a period is stable for all of it. A one-clock strobe marks the start of each period, in step with the registered output.

Top module: `spread_pulse_mod`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mod_out` and `cycle_start` are 0.
- R2: `cycle_start` is high for exactly one clock in every 2^N clocks and is never high in two consecutive cycles.
- R3: Position p of a period counts from 0 in the cycle in which `cycle_start` is high. For p > 0, `mod_out` at position p equals bit m of the held code, where m is the index of the highest set bit of p.
- R4: The number of high cycles of `mod_out` in one period equals the value of the code held for that period.
- R5: At position 0 (the `cycle_start` cycle), `mod_out` is always 0. With the code all ones, this is the only low cycle of the period.
- R6: With only the most significant code bit set, `mod_out` forms one contiguous high run of 2^(N-1) cycles, at positions 2^(N-1) through 2^N-1.
- R7: A code of zero keeps `mod_out` low for the whole period.
- R8: The code is captured at the period boundary. A change of `code_in` in the middle of a period has no effect on that period and applies from the next one.
- R9: The first high cycle of a period falls at position 2^j, where j is the lowest set bit of the code. Pulses appear in order from the least significant bit to the most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | CODE_W | Code that sets the duty cycle; sampled at each period boundary |
| mod_out | output | 1 | Registered modulated output |
| cycle_start | output | 1 | One-clock strobe at position 0 of each period |

## Verification
A wrong counter value misplaces pulses and the strobe. This shows on the first cycle with a mismatch, because the bench compares both outputs against its model on every clock. A corrupted held code changes the count of high cycles or where they fall, and shows at most one period later in the per-period totals. A hold register that follows the input mid-period appears within the same period, as soon as the changed bit's pulse slot arrives.

// File: rtl/sp_phase_counter.sv
module sp_phase_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CODE_W-1:0] phase,
  output logic              at_zero
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign at_zero = (phase == '0);
endmodule

// File: rtl/sp_run_decode.sv
module sp_run_decode #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] phase,
  output logic [CODE_W-1:0] run_vec
);
  // True while phase lies in [2^k, 2^(k+1)-1]: bit k set, nothing above it.
  function automatic logic first_run(input logic [CODE_W-1:0] ph, input int k);
    logic [CODE_W-1:0] upper;
    upper = ph >> (k + 1);
    return ph[k] && (upper == '0);
  endfunction

  for (genvar k = 0; k < CODE_W; k++) begin : g_run
    assign run_vec[k] = first_run(phase, k);
  end

  always_comb begin
    if (!$isunknown(phase)) begin
      assert_runs_disjoint_R3: assert ($onehot0(run_vec));
      if (phase == '0) begin
        assert_no_run_at_zero_R5: assert (run_vec == '0);
      end
    end
  end
endmodule

// File: rtl/spread_pulse_mod.sv
module spread_pulse_mod #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              mod_out,
  output logic              cycle_start
);
  logic [CODE_W-1:0] phase;
  logic              at_zero;
  logic [CODE_W-1:0] run_vec;
  logic [CODE_W-1:0] held_code;
  logic              pulse_hit;

  sp_phase_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .at_zero (at_zero)
  );

  sp_run_decode #(.CODE_W(CODE_W)) u_dec (
    .phase   (phase),
    .run_vec (run_vec)
  );

  assign pulse_hit = |(held_code & run_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_code   <= '0;
      mod_out     <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      if (at_zero) held_code <= code_in;
      mod_out     <= pulse_hit;
      cycle_start <= at_zero;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!mod_out && !cycle_start));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start);

  assert_strobe_phase_R2: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (phase == CODE_W'(1)));

  assert_low_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> !mod_out);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> $stable(held_code));
endmodule

// File: tb/sim_spread_pulse_mod.sv
module sim_spread_pulse_mod;
  localparam int W = 8;
  localparam int P = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] code_in = '0;
  logic         mod_out;
  logic         cycle_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int           mcnt = 0;
  logic [W-1:0] mheld = '0;
  logic         eout = 1'b0;
  logic         estr = 1'b0;

  bit           period_q[$];
  logic [W-1:0] pcode = '0;
  bit           have_pcode = 0;
  bit           mid_armed = 0;
  logic [W-1:0] mid_old = '0;
  int           reset_checks = 0;

  spread_pulse_mod #(.CODE_W(W)) u0 (
    .clk         (clk),
    .rst         (rst),
    .code_in     (code_in),
    .mod_out     (mod_out),
    .cycle_start (cycle_start)
  );

  always #4 clk = ~clk;

  function automatic int top_bit(input int v);
    int m = -1;
    while (v > 0) begin
      v = v >> 1;
      m++;
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mcnt = 0; mheld = '0; eout = 1'b0; estr = 1'b0;
    end else begin
      eout = (mcnt != 0) && mheld[top_bit(mcnt)];
      estr = (mcnt == 0);
      if (mcnt == 0) mheld = code_in;
      mcnt = (mcnt + 1) % P;
    end
  end

  task automatic analyze(input logic [W-1:0] c);
    int highs = 0;
    int first = -1;
    int rises = 0;
    for (int i = 0; i < P; i++) begin
      if (period_q[i]) begin
        highs++;
        if (first < 0) first = i;
        if (i == 0 || !period_q[i-1]) rises++;
      end
    end
    check(highs == int'(c), "R4 high count", highs, c);
    if (mid_armed) begin
      check(highs == int'(mid_old), "R8 mid-period change ignored", highs, mid_old);
      mid_armed = 0;
    end
    if (c == '1) begin
      check(highs == P - 1 && !period_q[0], "R5 all ones single low", highs, P - 1);
    end
    if (c == '0) check(highs == 0, "R7 zero code", highs, 0);
    if (c == (1 << (W - 1))) begin
      check(rises == 1 && first == P / 2, "R6 msb single run start", first, P / 2);
    end
    if (c != '0) begin
      int lo = 0;
      while (!c[lo]) lo++;
      check(first == (1 << lo), "R9 first pulse position", first, 1 << lo);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      if (reset_checks < 3) begin
        reset_checks++;
        check(mod_out == 1'b0 && cycle_start == 1'b0, "R1 reset outputs",
              {mod_out, cycle_start}, 0);
      end
    end else if (!done) begin
      check(cycle_start == estr, "R2 strobe", cycle_start, estr);
      check(mod_out == eout, "R3 output slot", mod_out, eout);
      if (cycle_start) begin
        if (have_pcode && period_q.size() == P) analyze(pcode);
        period_q.delete();
        pcode = mheld;
        have_pcode = 1;
      end
      if (have_pcode) period_q.push_back(mod_out);
    end
  end

  task automatic run_code(input logic [W-1:0] c, input int periods);
    code_in = c;
    repeat (periods * P) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(mod_out == 1'b0 && cycle_start == 1'b0, "R1 first cycle after reset",
          {mod_out, cycle_start}, 0);
    run_code(8'hB5, 2);
    run_code(8'hFF, 2);
    run_code(8'h00, 2);
    run_code(8'h80, 2);
    run_code(8'h01, 2);
    run_code(8'h4A, 2);
    // change in the middle of a period
    code_in = 8'h3C;
    while (!(mcnt == P / 2)) @(posedge clk);
    #2;
    mid_old   = 8'h3C;
    mid_armed = 1;
    code_in   = 8'hC3;
    repeat (3 * P) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule